// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a bus-attached peripheral that offers three 8-bit parallel ports (A, B and C) and one control register. Four locations are reached through a two-bit register address, one shared chip select, and read and write strobes. The strobes are sampled on the rising clock edge. Each port, or each nibble of port C, is set as input or output by a mode-set word written to the control register. Output ports drive latched values. Input ports return the live pin levels when they are read.

The same control location accepts a second kind of write. When the top bit is clear, the byte is a bit set/reset command. It changes exactly one port C latch bit and leaves every other bit unchanged. This lets software toggle individual port C lines as separate control lines. Only basic input/output is provided. Group mode fields are stored and read back, but they have no effect on behaviour. Pads are modelled as separate input, output and output-enable vectors.

Top module: `pport_ctrl`

## Requirements
- R1: With cs high, addr selects a location: 0 = port A, 1 = port B, 2 = port C, 3 = control register.
- R2: After synchronous reset every output-enable is 0 and every output latch is 0. A control read then returns 9Bh.
- R3: A control write with bit 7 = 1 is a mode-set word. In that word, bit 4 is the port A direction, bit 1 the port B direction, bit 3 the port C bits 7..4 direction and bit 0 the port C bits 3..0 direction. A value of 1 means input (enables 0) and 0 means output (enables all 1). For example, 82h makes A and C outputs and B an input.
- R4: A mode-set write clears the latches of all three ports to 0.
- R5: A control write with bit 7 = 0 is a bit set/reset. Bits 3..1 select a port C latch bit and bit 0 is its new value. All other port C bits keep their value, so 09h sets bit 4.
- R6: A bit set/reset write changes no output-enable and does not change the control readback value.
- R7: A data write to port A, B or C loads that port's whole latch, and the latch drives the port's out vector from the next cycle.
- R8: A read of port A or B, or of a port C nibble, returns the latch when that part is an output. When it is an input, the read returns the pin value present at the read edge. rdata is valid one cycle after the read edge and holds its value until the next read.
- R9: A control read returns the last mode-set word with bit 7 forced to 1. Group mode bits 6..5 and 2 are stored but do not change port behaviour.
- R10: Strobes with cs low change no latch, no enable and no rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enable |

## Verification
The assertions assume that the bus master holds cs, rd, wr, addr and wdata steady across each rising edge. They also assume the master does not expect an effect from a write in the same cycle as reset. The stimulus changes all inputs only on falling edges. It releases reset before any bus traffic starts. It draws random addresses, data and pin levels with a fixed seed, and it also issues some strobes with cs low. The directed part covers the 82h and 09h examples, reset readback, and set/reset of every port C bit position.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PORT_W = 8;
  localparam int SEL_W  = $clog2(PORT_W);
  localparam int HALF_W = PORT_W / 2;
  localparam logic [7:0] RESET_WORD = 8'h9B;

  typedef enum logic [1:0] {
    LOC_A    = 2'd0,
    LOC_B    = 2'd1,
    LOC_C    = 2'd2,
    LOC_CTRL = 2'd3
  } loc_e;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/pport_cfg.sv
module pport_cfg
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        wdata,
  output logic [7:0]        cfg_word,
  output dir_t              dir,
  output logic              mode_clr,
  output logic [PORT_W-1:0] bit_set,
  output logic [PORT_W-1:0] bit_clr
);
  logic              is_mode;
  logic [PORT_W-1:0] onehot;

  assign is_mode  = wdata[7];
  assign mode_clr = ctl_we & is_mode;

  always_comb begin
    onehot = '0;
    onehot[wdata[SEL_W:1]] = 1'b1;
  end

  assign bit_set = (ctl_we && !is_mode &&  wdata[0]) ? onehot : '0;
  assign bit_clr = (ctl_we && !is_mode && !wdata[0]) ? onehot : '0;

  always_ff @(posedge clk) begin
    if (rst)           cfg_word <= RESET_WORD;
    else if (mode_clr) cfg_word <= wdata;
  end

  assign dir.a_in  = cfg_word[4];
  assign dir.b_in  = cfg_word[1];
  assign dir.cu_in = cfg_word[3];
  assign dir.cl_in = cfg_word[0];
endmodule

// File: rtl/pport_latch.sv
module pport_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) q <= '0;
    else if (we)        q <= wdata;
    else                q <= (q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [1:0]        addr,
  input  dir_t              dir,
  input  logic [7:0]        cfg_word,
  input  logic [PORT_W-1:0] a_lat,
  input  logic [PORT_W-1:0] b_lat,
  input  logic [PORT_W-1:0] c_lat,
  input  logic [PORT_W-1:0] a_pin,
  input  logic [PORT_W-1:0] b_pin,
  input  logic [PORT_W-1:0] c_pin,
  output logic [PORT_W-1:0] rdata
);
  logic [PORT_W-1:0] sel;
  logic [PORT_W-1:0] c_view;

  assign c_view = { dir.cu_in ? c_pin[PORT_W-1:HALF_W] : c_lat[PORT_W-1:HALF_W],
                    dir.cl_in ? c_pin[HALF_W-1:0]      : c_lat[HALF_W-1:0] };

  always_comb begin
    unique case (loc_e'(addr))
      LOC_A:   sel = dir.a_in ? a_pin : a_lat;
      LOC_B:   sel = dir.b_in ? b_pin : b_lat;
      LOC_C:   sel = c_view;
      default: sel = cfg_word | 8'h80;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= sel;
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic              wen, ren;
  logic [7:0]        cfg_word;
  dir_t              dir;
  logic              mode_clr;
  logic [PORT_W-1:0] bit_set, bit_clr;
  logic [2:0]        port_we;
  logic [PORT_W-1:0] lat [3];
  logic [PORT_W-1:0] set_v [3];
  logic [PORT_W-1:0] clr_v [3];

  assign wen = cs & wr;
  assign ren = cs & rd;

  pport_cfg u_cfg (
    .clk(clk), .rst(rst), .ctl_we(wen && addr == LOC_CTRL), .wdata(wdata),
    .cfg_word(cfg_word), .dir(dir), .mode_clr(mode_clr),
    .bit_set(bit_set), .bit_clr(bit_clr)
  );

  for (genvar p = 0; p < 3; p++) begin : g_port
    assign port_we[p] = wen && (addr == 2'(p));
    assign set_v[p]   = (p == 2) ? bit_set : '0;
    assign clr_v[p]   = (p == 2) ? bit_clr : '0;
    pport_latch #(.W(PORT_W)) u_lat (
      .clk(clk), .rst(rst), .clr_all(mode_clr), .we(port_we[p]),
      .wdata(wdata), .set_m(set_v[p]), .clr_m(clr_v[p]), .q(lat[p])
    );
  end

  pport_rdmux u_rd (
    .clk(clk), .rst(rst), .re(ren), .addr(addr), .dir(dir), .cfg_word(cfg_word),
    .a_lat(lat[0]), .b_lat(lat[1]), .c_lat(lat[2]),
    .a_pin(pa_in), .b_pin(pb_in), .c_pin(pc_in), .rdata(rdata)
  );

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pc_out = lat[2];
  assign pa_oe  = {PORT_W{~dir.a_in}};
  assign pb_oe  = {PORT_W{~dir.b_in}};
  assign pc_oe  = {{HALF_W{~dir.cu_in}}, {HALF_W{~dir.cl_in}}};
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
             pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R2

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && wdata[7]) |=>
      (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R4

  AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !wdata[7]) |=>
      ($countones(pc_out ^ $past(pc_out)) <= 1)); // R5

  AST_BSR_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !wdata[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R6

  AST_PORT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd0) |=> (pa_out == $past(wdata))); // R7

  AST_NOCS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(rdata) && $stable(pa_out) && $stable(pb_out) &&
             $stable(pc_out) && $stable(pc_oe))); // R10

  AST_OE_GROUPS: assert property (@(posedge clk) disable iff (rst)
    ((pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
     (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) &&
     (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF))); // R3
endmodule

bind pport_ctrl pport_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/pport_ctrl_test.sv
module pport_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] m_lat [3];
  logic [7:0] m_cfg;
  logic [7:0] m_rd;

  always #5 clk = ~clk;

  pport_ctrl uut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_oe(input int p);
    case (p)
      0: return m_cfg[4] ? 8'h00 : 8'hFF;
      1: return m_cfg[1] ? 8'h00 : 8'hFF;
      default: return {m_cfg[3] ? 4'h0 : 4'hF, m_cfg[0] ? 4'h0 : 4'hF};
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cfg[4] ? pa_in : m_lat[0];
      2'd1: return m_cfg[1] ? pb_in : m_lat[1];
      2'd2: return {m_cfg[3] ? pc_in[7:4] : m_lat[2][7:4],
                    m_cfg[0] ? pc_in[3:0] : m_lat[2][3:0]};
      default: return m_cfg | 8'h80;
    endcase
  endfunction

  task automatic check_pins(input string req);
    check({req, " pa_out"}, pa_out, m_lat[0]);
    check({req, " pb_out"}, pb_out, m_lat[1]);
    check({req, " pc_out"}, pc_out, m_lat[2]);
    check({req, " pa_oe"},  pa_oe,  exp_oe(0));
    check({req, " pb_oe"},  pb_oe,  exp_oe(1));
    check({req, " pc_oe"},  pc_oe,  exp_oe(2));
  endtask

  // R1 R3 R4 R5 R7: write then compare ports
  task automatic do_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (sel) begin
      if (a == 2'd3) begin
        if (d[7]) begin m_cfg = d; m_lat[0] = 0; m_lat[1] = 0; m_lat[2] = 0; end
        else m_lat[2][d[3:1]] = d[0];
      end else m_lat[a] = d;
    end
    check_pins(sel ? "R7/R5/R4/R3" : "R10 write");
  endtask

  // R8 R9 R1: read, rdata valid next cycle
  task automatic do_read(input logic [1:0] a, input logic sel);
    @(negedge clk);
    cs = sel; rd = 1'b1; addr = a;
    if (sel) m_rd = exp_read(a);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    check(sel ? "R8/R9/R1 read" : "R10 read", rdata, m_rd);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_lat[0] = 0; m_lat[1] = 0; m_lat[2] = 0; m_cfg = 8'h9B; m_rd = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    check_pins("R2");
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h7E;
    do_read(2'd3, 1'b1);
    check("R2 ctrl readback", rdata, 8'h9B);
    do_read(2'd0, 1'b1);
    check("R2 input pins A", rdata, 8'h5A);
    // R3 82h example
    do_write(2'd3, 8'h82, 1'b1);
    check("R3 pa_oe for 82h", pa_oe, 8'hFF);
    check("R3 pb_oe for 82h", pb_oe, 8'h00);
    check("R3 pc_oe for 82h", pc_oe, 8'hFF);
    // R5 09h sets bit 4
    do_write(2'd3, 8'h09, 1'b1);
    check("R5 09h", pc_out, 8'h10);
    // R5 R6 every bit position set then clear
    for (int b = 0; b < 8; b++) begin
      do_write(2'd3, 8'(b * 2 + 1), 1'b1);
      do_read(2'd3, 1'b1);
    end
    check("R5 all set", pc_out, 8'hFF);
    for (int b = 0; b < 8; b++) do_write(2'd3, 8'(b * 2), 1'b1);
    check("R5 all clear", pc_out, 8'h00);
    // R9 mode fields ignored
    do_write(2'd3, 8'h6C, 1'b1);
    do_write(2'd3, 8'hE5, 1'b1);
    do_read(2'd3, 1'b1);
    check("R9 readback E5", rdata, 8'hE5);
    // R4 clear after data
    do_write(2'd0, 8'hA5, 1'b1);
    do_write(2'd3, 8'h80, 1'b1);
    check("R4 latch cleared", pa_out, 8'h00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      if (r[1:0] == 2'd0) do_read(2'(r[3:2]), r[7:4] != 0);
      else if (r[1:0] == 2'd1) do_write(2'd3, 8'($urandom), r[7:4] != 0);
      else if (r[1:0] == 2'd2) do_write(2'(r[3:2]), 8'($urandom), r[7:4] != 0);
      else do_read(2'(r[3:2]), 1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule